// File: doc/BRIEF.md
# Split-Window Bank Mapper

This block sits on the cartridge side of a console bus that has 13 address lines. It turns console accesses into addresses for an external ROM. The cartridge owns the 4 KB window where address bit 12 is high. That window is split in two 2 KB halves. The upper half always shows the final 2 KB bank of the ROM image, so the reset and interrupt vectors are present from power-up. The lower half shows whichever 2 KB bank was last selected.

Software selects a bank by writing the bank number to address $03F. That address lies outside the cartridge window, in the low register page. The mapper snoops the data bus on that write and latches an 8-bit bank register. Only as many low bits as the fitted ROM needs take part in the lookup, so bank numbers wrap modulo the number of banks present. The ROM size is a parameter: a power of two, at least 4 KB.

Top module: `split_bank_mapper`

## Requirements
- R1: `romCe` is high exactly when `cpuAddr[12]` is high, whatever the other inputs are.
- R2: When `cpuAddr[12]` and `cpuAddr[11]` are both high, `romAddr` is the last bank (ROM_BANKS-1) in its upper bits and `cpuAddr[10:0]` in its low 11 bits, whatever value the bank register holds.
- R3: When `cpuAddr[12]` is high and `cpuAddr[11]` is low, `romAddr` is the selected bank in its upper bits and `cpuAddr[10:0]` in its low 11 bits.
- R4: On a clock edge where `wrStrobe` is high, `cpuAddr[12]` is low and `cpuAddr[11:0]` equals 12'h03F, the bank register loads `cpuData`. The new bank shows in the lower half from the next cycle on.
- R5: A write to any other address leaves the selected bank unchanged. This includes $103F inside the window, $03E, and $043F, which differs only in bit 10.
- R6: A read of $03F (`wrStrobe` low) leaves the selected bank unchanged.
- R7: While `rstN` is low the selected bank is 0 and hotspot writes are ignored. After reset is released, the lower half shows bank 0.
- R8: The bank shown in the lower half is the latched 8-bit value modulo ROM_BANKS. With 4 banks, 6 selects bank 2 and 255 selects bank 3.
- R9: `dataOe` is high exactly when `cpuAddr[12]` is high and `wrStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 13 | Console address bus |
| cpuData | input | 8 | Console data bus, sampled on a hotspot write |
| wrStrobe | input | 1 | High for a qualified write cycle |
| romAddr | output | 11+log2(ROM_BANKS) | Address to the ROM device |
| romCe | output | 1 | ROM chip enable |
| dataOe | output | 1 | Enable for the cartridge data drivers |

## Verification
The hardest cases are the near-miss hotspot addresses. A write must be rejected when it differs from $03F in a single bit, including bit 12, which places it inside the window. The stimulus writes a distinctive bank value to each near-miss address. Every such write is followed by a lower-half read, so a wrong capture shows up as a wrong ROM address. Bank values above the fitted ROM size and a reset asserted in mid-run after a non-zero bank are also driven. Each case is compared cycle by cycle against a behavioural model.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
  typedef struct packed {
    logic bankLoad;   // hotspot write seen this cycle
    logic winHit;     // access falls in cartridge window
    logic upperHalf;  // access targets fixed half
    logic readOut;    // cartridge should drive the data bus
  } sbmStrobes_t;
endpackage

// File: rtl/sbm_ctrl.sv
`timescale 1ns/1ps
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-2:0] HOT_ADDR = 'h03F
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wrStrobe,
  output sbmStrobes_t       strobes
);
  localparam int OFF_W = ADDR_W - 1;

  logic inWindow;
  logic hotMatch;

  assign inWindow = cpuAddr[ADDR_W-1];
  assign hotMatch = (cpuAddr[OFF_W-1:0] == HOT_ADDR);

  always_comb begin
    strobes.winHit    = inWindow;
    strobes.upperHalf = cpuAddr[OFF_W-1];
    strobes.bankLoad  = wrStrobe && !inWindow && hotMatch;
    strobes.readOut   = inWindow && !wrStrobe;
  end
endmodule

// File: rtl/sbm_datapath.sv
`timescale 1ns/1ps
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int ROM_BANKS = 4,
  parameter int HALF_W    = 11,
  localparam int SEL_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW   = HALF_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbmStrobes_t       strobes,
  input  logic [BANK_W-1:0] cpuData,
  input  logic [HALF_W-1:0] halfOffset,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romCe,
  output logic              dataOe
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(ROM_BANKS - 1);

  logic [BANK_W-1:0] bankReg;
  logic [SEL_W-1:0]  bankSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bankReg <= '0;
    else if (strobes.bankLoad) bankReg <= cpuData;
  end

  always_comb begin
    bankSel = strobes.upperHalf ? LAST_SEL : bankReg[SEL_W-1:0];
    romAddr = {bankSel, halfOffset};
    romCe   = strobes.winHit;
    dataOe  = strobes.readOut;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bankLoad |=> bankReg == $past(cpuData)); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bankLoad |=> $stable(bankReg)); // R5
  AST_RESET_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> bankReg == '0); // R7
endmodule

// File: rtl/split_bank_mapper.sv
`timescale 1ns/1ps
module split_bank_mapper
  import sbm_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int ROM_BANKS = 4,
  localparam int ADDR_W   = 13,
  localparam int HALF_W   = ADDR_W - 2,
  localparam int ROM_AW   = HALF_W + $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [BANK_W-1:0] cpuData,
  input  logic              wrStrobe,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romCe,
  output logic              dataOe
);
  sbmStrobes_t strobes;

  sbm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .cpuAddr (cpuAddr),
    .wrStrobe(wrStrobe),
    .strobes (strobes)
  );

  sbm_datapath #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS), .HALF_W(HALF_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpuData   (cpuData),
    .halfOffset(cpuAddr[HALF_W-1:0]),
    .romAddr   (romAddr),
    .romCe     (romCe),
    .dataOe    (dataOe)
  );

  AST_FIXED_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1] && cpuAddr[ADDR_W-2]) |-> (romAddr[ROM_AW-1:HALF_W] == '1)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    romCe |-> (romAddr[HALF_W-1:0] == cpuAddr[HALF_W-1:0])); // R3
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> romCe); // R9
  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !dataOe); // R9
endmodule

// File: tb/split_bank_mapper_tb.sv
`timescale 1ns/1ps
module split_bank_mapper_tb_top;
  localparam int NB = 4;
  localparam int AW = 11 + $clog2(NB);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [12:0]   cpuAddr = '0;
  logic [7:0]    cpuData = '0;
  logic          wrStrobe = 1'b0;
  logic [AW-1:0] romAddr;
  logic          romCe;
  logic          dataOe;

  logic [7:0] rom [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;
  int modelBank = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_bank_mapper #(.BANK_W(8), .ROM_BANKS(NB)) dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .wrStrobe(wrStrobe), .romAddr(romAddr), .romCe(romCe), .dataOe(dataOe)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%0h", req, act, exp, cpuAddr);
    end
  endtask

  task automatic step(input logic [12:0] a, input logic [7:0] d, input logic w,
                      input string tag);
    int expAddr;
    @(negedge clk);
    cpuAddr = a; cpuData = d; wrStrobe = w;
    #1;
    chk(int'(romCe), int'(a[12]), "R1");
    chk(int'(dataOe), int'(a[12] && !w), "R9");
    if (a[12]) begin
      if (a[11]) expAddr = ((NB - 1) << 11) | int'(a[10:0]);
      else       expAddr = ((modelBank % NB) << 11) | int'(a[10:0]);
      chk(int'(romAddr), expAddr, tag);
      chk(int'(rom[romAddr]), int'(rom[expAddr]), tag);
    end
    @(posedge clk);
    if (rstN && w && !a[12] && a[11:0] == 12'h03F) modelBank = int'(d);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) rom[i] = 8'((i * 37) ^ (i >> 8));
    step(13'h003F, 8'h02, 1'b1, "R7");   // write during reset ignored
    step(13'h1000, 8'h00, 1'b0, "R7");
    @(negedge clk); rstN = 1'b1;
    step(13'h1234, 8'h00, 1'b0, "R7");
    step(13'h1800, 8'h00, 1'b0, "R2");
    step(13'h1FFC, 8'h00, 1'b0, "R2");
    step(13'h003F, 8'h01, 1'b1, "R4");
    step(13'h1123, 8'h00, 1'b0, "R4");   // first cycle after load
    step(13'h003E, 8'h02, 1'b1, "R5");
    step(13'h1456, 8'h00, 1'b0, "R5");
    step(13'h103F, 8'h03, 1'b1, "R5");   // inside window
    step(13'h103F, 8'h00, 1'b0, "R5");
    step(13'h043F, 8'h03, 1'b1, "R5");
    step(13'h1010, 8'h00, 1'b0, "R5");
    step(13'h003F, 8'h02, 1'b0, "R6");   // read of hotspot
    step(13'h1777, 8'h00, 1'b0, "R6");
    step(13'h003F, 8'h06, 1'b1, "R8");
    step(13'h1001, 8'h00, 1'b0, "R8");
    step(13'h1FFD, 8'h00, 1'b0, "R2");
    step(13'h003F, 8'hFF, 1'b1, "R8");
    step(13'h17FF, 8'h00, 1'b0, "R8");
    step(13'h0800, 8'h00, 1'b0, "R1");
    for (int b = 0; b < 10; b++) begin
      step(13'h003F, 8'(b * 5), 1'b1, "R4");
      step(13'(13'h1000 | (b * 201)), 8'h00, 1'b0, "R3");
      step(13'(13'h1800 | (b * 97)), 8'h00, 1'b0, "R2");
    end
    step(13'h003F, 8'h02, 1'b1, "R4");
    @(negedge clk); rstN = 1'b0; modelBank = 0;
    step(13'h1200, 8'h00, 1'b0, "R7");
    @(negedge clk); rstN = 1'b1;
    step(13'h1300, 8'h00, 1'b0, "R7");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule